// File: doc/BRIEF.md
# Zero-turnaround flow-through synchronous SRAM

A synthesizable behavioural model of a synchronous SRAM whose bus can switch from a read to a write, or back, on consecutive clocks with no idle cycle. Each access starts with an address-load edge. That edge latches the address, the access kind and the chip selection. A burst of up to four beats then follows, with the low two address bits advanced in linear or interleaved order. Read data comes straight from the array to the outputs with no output register, so it is valid in the clock period right after the edge that registered the access.

Write data and per-lane write masks arrive one edge after their address. The data word is 36 bits wide, made of four 9-bit lanes. A clock-enable input freezes the whole model on any edge. A snooze input puts it in a standby state that keeps the array contents and ignores every other input. The depth is a parameter, so the array stays small in simulation.

Top module: `zt_flow_sram`

## Requirements
- R1: On an enabled edge with `adv_i` low and the part selected, the address is latched. For a read, the array word at that address is on `rdata_o` in the period right after that edge.
- R2: `wr_ni` is sampled only on load edges (low = write, high = read). On advance edges the latched access kind holds, whatever `wr_ni` does.
- R3: With `order_i` low, enabled advance edges step the low two address bits as (start + n) mod 4, for n = 0..3. The upper bits stay fixed.
- R4: With `order_i` high, the beat address low bits are start XOR n.
- R5: The write data and `bw_ni` for a beat are sampled on the edge after that beat's address edge. Bit i of `bw_ni` (active low) guards lane i, which is data bits 9i+8..9i. Lanes whose bit is high keep their old value.
- R6: A read loaded on the same edge that takes the data of the preceding write returns the newly written data, with no idle cycle between them.
- R7: A load selects the part only if `sel_ni` is low, `sel_i` is high and `sel_alt_ni` is low. A deselected load ends any burst, and later advances stay inactive. In that state `drive_o` is low and `rdata_o` is zero.
- R8: `drive_o` is high only during read data phases while `oe_ni` is low. During write data phases it is low.
- R9: An edge with `cen_ni` high is ignored completely. The address, the burst count, the pending write data capture and the outputs all hold.
- R10: While `snooze_i` is high, edges are ignored and `drive_o` is low. The array keeps its contents, and operation resumes normally once `snooze_i` falls.
- R11: After reset no access is active, `drive_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| sel_ni | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| sel_alt_ni | input | 1 | Second chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| wr_ni | input | 1 | Access kind at load: low write, high read |
| adv_i | input | 1 | High advances the burst, low loads a new address |
| bw_ni | input | 4 | Per-lane write enables, active low |
| order_i | input | 1 | Burst order: low linear, high interleaved |
| snooze_i | input | 1 | Standby request, active high |
| addr_i | input | AW | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Flow-through read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
Read data and the drive enable for an access are due in the same period as the edge that registered it. The bench therefore samples them 1 ns after that edge, before it changes any input. A write reaches the array on the following edge, so its effect becomes visible only in the period after that second edge. The bench reference array is updated at that point as well. Because stalled or snoozed edges must leave everything unchanged, the bench repeats the previous expected values after each such edge.

// File: rtl/zt_flow_pkg.sv
package zt_flow_pkg;
  localparam int LANE_W  = 9;
  localparam int N_LANES = 4;
  localparam int DATA_W  = LANE_W * N_LANES;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // low two address bits of beat n within a burst starting at base
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] n,
                                         input burst_ord_e ord);
    logic [1:0] r;
    case (ord)
      ORD_INTERLEAVE: r = base ^ n;
      default:        r = base + n;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
  import zt_flow_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_en_i,
  input  logic          load_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic          act_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o
);
  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en_i) begin
      if (load_i) begin
        act_q  <= sel_i;
        wr_q   <= wr_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign act_o  = act_q;
  assign wr_o   = wr_q;
  assign addr_o = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_q, burst_ord_e'(order_i))};

  assert_type_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_i) |=> $stable(wr_q));

  assert_beat_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_i && act_q) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  assert_deselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && load_i && !sel_i) |=> !act_q);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> ($stable(base_q) && $stable(cnt_q) && $stable(act_q) && $stable(wr_q)));
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LW     = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g]) mem_q[waddr_i] <= wdata_i[g*LW +: LW];
    end

    assign rdata_o[g*LW +: LW] = mem_q[raddr_i];
  end
endmodule

// File: rtl/zt_flow_sram.sv
module zt_flow_sram
  import zt_flow_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cen_ni,
  input  logic                sel_ni,
  input  logic                sel_i,
  input  logic                sel_alt_ni,
  input  logic                oe_ni,
  input  logic                wr_ni,
  input  logic                adv_i,
  input  logic [N_LANES-1:0]  bw_ni,
  input  logic                order_i,
  input  logic                snooze_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                drive_o
);
  logic              step_en, selected, act, wr, wr_commit, rd_phase;
  logic [AW-1:0]     acc_addr;
  logic [DATA_W-1:0] arr_rd;

  assign step_en  = !cen_ni && !snooze_i;
  assign selected = !sel_ni && sel_i && !sel_alt_ni;

  zt_burst_ctl #(.AW(AW)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_en_i (step_en),
    .load_i    (!adv_i),
    .sel_i     (selected),
    .wr_i      (!wr_ni),
    .order_i   (order_i),
    .addr_i    (addr_i),
    .act_o     (act),
    .wr_o      (wr),
    .addr_o    (acc_addr)
  );

  // write data phase: data and mask sampled on the edge closing the beat
  assign wr_commit = step_en && act && wr;
  assign rd_phase  = act && !wr;

  zt_lane_array #(.AW(AW), .LANES(N_LANES), .LW(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .waddr_i (acc_addr),
    .wmask_i (~bw_ni),
    .wdata_i (wdata_i),
    .raddr_i (acc_addr),
    .rdata_o (arr_rd)
  );

  assign rdata_o = rd_phase ? arr_rd : '0;
  assign drive_o = rd_phase && !oe_ni && !snooze_i;

  assert_write_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && wr) |-> !drive_o);

  assert_snooze_dark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |-> !drive_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (rdata_o == '0 && !drive_o));
endmodule

// File: tb/zt_flow_sram_test.sv
module zt_flow_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cen_ni = 1'b0, sel_ni = 1'b0, sel_i = 1'b1, sel_alt_ni = 1'b0;
  logic          oe_ni = 1'b0, wr_ni = 1'b1, adv_i = 1'b1, order_i = 1'b0, snooze_i = 1'b0;
  logic [3:0]    bw_ni = 4'h0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] ref_mem [1<<AW];
  logic          m_act = 1'b0, m_wr = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [DW-1:0] pat = 36'h1_2345_6789;

  always #4 clk = ~clk;

  zt_flow_sram #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .sel_ni(sel_ni), .sel_i(sel_i),
    .sel_alt_ni(sel_alt_ni), .oe_ni(oe_ni), .wr_ni(wr_ni), .adv_i(adv_i), .bw_ni(bw_ni),
    .order_i(order_i), .snooze_i(snooze_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = order_i ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [DW-1:0] exp_d;
    logic          exp_dr;
    exp_d  = (m_act && !m_wr) ? ref_mem[m_addr()] : '0;
    exp_dr = m_act && !m_wr && !oe_ni && !snooze_i;
    check({tag, " rdata"}, rdata_o, exp_d);
    check({tag, " drive"}, {35'd0, drive_o}, {35'd0, exp_dr});
  endtask

  // one clock: drive inputs, advance reference at the edge, check 1 ns later
  task automatic step(input logic adv, input logic wn, input logic [AW-1:0] a, input string tag);
    logic en, sel;
    adv_i = adv; wr_ni = wn; addr_i = a;
    pat = {pat[34:0], pat[35] ^ pat[24]} ^ 36'h0_0F0F_0A51;
    wdata_i = pat;
    @(posedge clk);
    en  = !cen_ni && !snooze_i;
    sel = !sel_ni && sel_i && !sel_alt_ni;
    if (en) begin
      if (m_act && m_wr)
        for (int l = 0; l < 4; l++)
          if (!bw_ni[l]) ref_mem[m_addr()][l*9 +: 9] = wdata_i[l*9 +: 9];
      if (!adv) begin
        m_act = sel; m_wr = !wn; m_base = a; m_cnt = '0;
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1;
      end
    end
    #1;
    check_outputs(tag);
  endtask

  task automatic burst(input logic wr, input logic [AW-1:0] base, input string tag);
    step(1'b0, !wr, base, tag);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, '0, tag);
  endtask

  task automatic t_reset();
    #1;
    check("R11 rdata", rdata_o, '0);
    check("R11 drive", {35'd0, drive_o}, 36'd0);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, '0, "R11");
  endtask

  task automatic t_linear();
    order_i = 1'b0; bw_ni = 4'h0;
    burst(1'b1, 6'd5, "R3 wr");
    burst(1'b0, 6'd5, "R3 R1 R6");  // load edge takes last write beat
    burst(1'b1, 6'd16, "R3 wr");
    burst(1'b0, 6'd18, "R3 R1");
  endtask

  task automatic t_interleave();
    order_i = 1'b1; bw_ni = 4'h0;
    burst(1'b1, 6'd10, "R4 wr");
    burst(1'b0, 6'd10, "R4 R6");
    burst(1'b0, 6'd11, "R4");
    burst(1'b0, 6'd9,  "R4");
    order_i = 1'b0;
  endtask

  task automatic t_mask();
    bw_ni = 4'h0;
    step(1'b0, 1'b0, 6'd33, "R5 wr");
    bw_ni = 4'b1010;                      // lanes 0 and 2 written
    step(1'b0, 1'b0, 6'd33, "R5 wr");
    bw_ni = 4'b0111;                      // lane 3 only
    step(1'b0, 1'b1, 6'd33, "R5 R6");
    bw_ni = 4'h0;
    step(1'b0, 1'b1, 6'd33, "R5");
  endtask

  task automatic t_type_hold();
    step(1'b0, 1'b1, 6'd4, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, "R2");   // wr_ni low on advance
    burst(1'b0, 6'd4, "R2 reread");
    step(1'b0, 1'b0, 6'd20, "R2 wr");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, '0, "R2 wr");
    burst(1'b0, 6'd20, "R2 R8");
  endtask

  task automatic t_select();
    step(1'b0, 1'b1, 6'd5, "R7 sel");
    sel_i = 1'b0;
    step(1'b0, 1'b1, 6'd5, "R7 desel");
    sel_i = 1'b1;
    step(1'b1, 1'b1, '0, "R7 adv idle");
    sel_ni = 1'b1;
    step(1'b0, 1'b1, 6'd6, "R7 desel");
    sel_ni = 1'b0; sel_alt_ni = 1'b1;
    step(1'b0, 1'b0, 6'd6, "R7 desel");
    step(1'b1, 1'b1, '0, "R7 no write");
    sel_alt_ni = 1'b0;
    burst(1'b0, 6'd4, "R7 intact");
  endtask

  task automatic t_oe();
    oe_ni = 1'b1;
    burst(1'b0, 6'd16, "R8 oe");
    oe_ni = 1'b0;
    burst(1'b1, 6'd40, "R8 wr");
    burst(1'b0, 6'd40, "R8");
  endtask

  task automatic t_stall();
    step(1'b0, 1'b1, 6'd16, "R9");
    step(1'b1, 1'b1, '0, "R9");
    cen_ni = 1'b1;
    step(1'b0, 1'b0, 6'd1, "R9 stall");
    step(1'b1, 1'b1, '0, "R9 stall");
    cen_ni = 1'b0;
    step(1'b1, 1'b1, '0, "R9");
    step(1'b0, 1'b0, 6'd44, "R9 wr");
    cen_ni = 1'b1;
    step(1'b1, 1'b1, '0, "R9 stall wr");
    cen_ni = 1'b0;
    step(1'b0, 1'b1, 6'd44, "R9 R6");
  endtask

  task automatic t_snooze();
    burst(1'b1, 6'd48, "R10 wr");
    step(1'b0, 1'b1, 6'd48, "R10");
    snooze_i = 1'b1;
    step(1'b0, 1'b0, 6'd48, "R10 snz");
    step(1'b1, 1'b1, '0, "R10 snz");
    step(1'b0, 1'b0, 6'd5, "R10 snz");
    snooze_i = 1'b0;
    step(1'b1, 1'b1, '0, "R10 resume");
    burst(1'b0, 6'd48, "R10 kept");
    burst(1'b0, 6'd5, "R10 kept");
  endtask

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_mask();
    t_type_hold();
    t_select();
    t_oe();
    t_stall();
    t_snooze();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule